// File: doc/BRIEF.md
# Serial Peripheral Word Master

This block runs a single full-duplex word exchange on an SPI bus. It can address any one of several peripherals, and each peripheral has its own active-low select line. A one-cycle `start` pulse loads the outgoing word and captures the transfer settings: word length, clock idle level, clock phase, target peripheral and clock divider. The block then lowers the chosen select line and produces the serial clock. It shifts the word out on `mosi` with the least significant bit first and captures one `miso` bit for every bit it sends.

The outgoing and incoming bits share one shift register. Each captured bit enters at the top of the active word, so once the last bit is in, `rx_word` holds the reply right-aligned. The select line stays low for the whole word and rises before `done` pulses. Most peripherals use 8-bit words, but the length can be set anywhere from 3 to 16 bits per transfer.

Top module: `spi_word_master`

## Requirements
- R1: `word_len` is an unsigned bit count. Values 3..16 are used as given, values below 3 act as 3, and values above 16 act as 16. A word of N bits produces exactly N serial clock pulses.
- R2: Whenever no word is in progress, `sclk` rests at the level of `cpol` (0 = low, 1 = high). It also returns to that level after the last pulse of a word.
- R3: With `cpha` = 0, the first bit is on `mosi` before the first clock edge, bits are captured on leading edges and changed on trailing edges. With `cpha` = 1, bits change on leading edges and are captured on trailing edges. A leading edge is a transition away from the idle level.
- R4: `tx_word` bit 0 goes out first. Each captured `miso` bit enters at bit N-1 and moves down one place per bit. At `done`, `rx_word[N-1:0]` holds the reply, with the first received bit at bit 0, and the bits above N-1 read zero.
- R5: `ss_n[k]` goes low only for the peripheral with `slave_idx` = k. At most one select line is ever low.
- R6: The select line falls at least one half-period before the first clock edge and rises at least one half-period after the last one. It does not change while a word is in progress.
- R7: Each half-period of `sclk` lasts `divider`+1 system clocks. `done` is visible exactly (2N+2)·(`divider`+1) clocks after the edge that accepts `start`.
- R8: `busy` is high from the accepting edge until the edge that raises `done`. `done` lasts one cycle, and the select lines are all high when it appears.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The current word is unaffected and no further word follows.
- R10: Every setting is captured at the accepting edge. Changing any input during a word has no effect on that word.
- R11: A `start` pulse that is high in the cycle where `done` is visible is accepted, so words can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a word exchange (one-cycle pulse) |
| tx_word | input | MAX_BITS | Word to send, LSB first |
| word_len | input | LEN_W | Bits per word, clamped to 3..MAX_BITS |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| slave_idx | input | SEL_W | Index of the select line to lower |
| divider | input | DIV_W | Half-period length minus one, in system clocks |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| ss_n | output | NUM_SLAVES | Active-low select, one per peripheral |
| rx_word | output | MAX_BITS | Received word, valid at done |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the finish of a word, when `done` shows and `busy` drops, and a new `start` request. The bench raises `start` in exactly the cycle where `done` is visible. It then judges the second word by its reply, its exact cycle count and its select and clock timing, all computed from the requirements. In a separate run it pulses `start` in the middle of a word and checks that the timing and reply are unchanged and that the bus stays idle afterwards.

// File: rtl/spi_word_master.sv
`timescale 1ns/1ps
module spi_word_master #(
  parameter int NUM_SLAVES = 4,
  parameter int MAX_BITS   = 16,
  parameter int DIV_W      = 8,
  parameter int SEL_W      = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1,
  parameter int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [MAX_BITS-1:0]   tx_word,
  input  logic [LEN_W-1:0]      word_len,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic [SEL_W-1:0]      slave_idx,
  input  logic [DIV_W-1:0]      divider,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic [NUM_SLAVES-1:0] ss_n,
  output logic [MAX_BITS-1:0]   rx_word,
  output logic                  busy,
  output logic                  done
);
  localparam int MIN_BITS = 3;
  localparam int EDGE_W   = $clog2(2 * MAX_BITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_RUN, S_TAIL} state_t;

  state_t                  state;
  logic [DIV_W-1:0]        div_q, div_cnt;
  logic [LEN_W-1:0]        len_q, len_c;
  logic                    cpha_q, smp, sclk_r, done_r;
  logic [EDGE_W-1:0]       edge_idx;
  logic [MAX_BITS-1:0]     sr, sr_nx, mask_c, top_bit;
  logic [NUM_SLAVES-1:0]   ss_r;

  always_comb begin
    if (word_len < LEN_W'(MIN_BITS))      len_c = LEN_W'(MIN_BITS);
    else if (word_len > LEN_W'(MAX_BITS)) len_c = LEN_W'(MAX_BITS);
    else                                  len_c = word_len;
  end

  assign mask_c  = {MAX_BITS{1'b1}} >> (LEN_W'(MAX_BITS) - len_c);
  assign top_bit = {{(MAX_BITS-1){1'b0}}, 1'b1} << (len_q - 1'b1);
  assign sr_nx   = (sr >> 1) | ({MAX_BITS{smp}} & top_bit);

  wire              tick     = (state != S_IDLE) && (div_cnt == div_q);
  wire [EDGE_W-1:0] last_idx = EDGE_W'({len_q, 1'b0}) - EDGE_W'(1);
  wire              in_run   = (state == S_RUN);
  wire              samp_evt = tick && in_run && (edge_idx[0] == cpha_q);
  wire              shift_evt = tick && ((in_run && (cpha_q ? (!edge_idx[0] && edge_idx != '0)
                                                            : edge_idx[0]))
                                         || (state == S_TAIL && cpha_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      div_q    <= '0;
      div_cnt  <= '0;
      len_q    <= LEN_W'(MIN_BITS);
      cpha_q   <= 1'b0;
      smp      <= 1'b0;
      sclk_r   <= 1'b0;
      done_r   <= 1'b0;
      edge_idx <= '0;
      sr       <= '0;
      ss_r     <= '1;
    end else begin
      done_r <= 1'b0;
      if (samp_evt)  smp <= miso;
      if (shift_evt) sr  <= sr_nx;
      if (state == S_IDLE) begin
        sclk_r <= cpol;
        if (start) begin
          state    <= S_LEAD;
          div_q    <= divider;
          div_cnt  <= '0;
          len_q    <= len_c;
          cpha_q   <= cpha;
          edge_idx <= '0;
          sr       <= tx_word & mask_c;
          ss_r     <= ~(NUM_SLAVES'(1) << slave_idx);
        end
      end else begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          case (state)
            S_LEAD: state <= S_RUN;
            S_RUN: begin
              sclk_r   <= ~sclk_r;
              edge_idx <= edge_idx + 1'b1;
              if (edge_idx == last_idx) state <= S_TAIL;
            end
            S_TAIL: begin
              state  <= S_IDLE;
              ss_r   <= '1;
              done_r <= 1'b1;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign sclk    = sclk_r;
  assign mosi    = sr[0];
  assign ss_n    = ss_r;
  assign rx_word = sr;
  assign busy    = (state != S_IDLE);
  assign done    = done_r;
endmodule

// File: rtl/spi_word_master_chk.sv
`timescale 1ns/1ps
module spi_word_master_chk #(
  parameter int NUM_SLAVES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpol,
  input logic                  sclk,
  input logic [NUM_SLAVES-1:0] ss_n,
  input logic                  busy,
  input logic                  done
);
  assert_one_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ss_n) <= 1);

  assert_select_tracks_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&ss_n) == !busy);

  assert_select_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ss_n));

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && $past(rst_n) |-> sclk == $past(cpol));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind spi_word_master spi_word_master_chk #(.NUM_SLAVES(NUM_SLAVES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .sclk(sclk),
  .ss_n(ss_n), .busy(busy), .done(done)
);

// File: tb/spi_word_master_test.sv
`timescale 1ns/1ps
module spi_word_master_test;
  logic        clk = 0, rst_n = 0, start = 0, cpol = 0, cpha = 0, miso_r = 0;
  logic [15:0] tx_word = 0;
  logic [4:0]  word_len = 8;
  logic [1:0]  slave_idx = 0;
  logic [7:0]  divider = 0;
  logic        sclk, mosi, busy, done;
  logic [3:0]  ss_n;
  logic [15:0] rx_word;

  spi_word_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .word_len(word_len),
    .cpol(cpol), .cpha(cpha), .slave_idx(slave_idx), .divider(divider), .miso(miso_r),
    .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .rx_word(rx_word), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  int e_n, e_div, e_cpol, m_cpha, m_idx;
  logic [15:0] e_tx, e_stx, srx;
  int cnt, edges, t_sel, t_first, t_last, t_rise, bad_sel;
  logic prev_act = 0, prev_sclk = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // peripheral model and bus monitor, acting half a clock after each edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic act, lead;
      for (int j = 0; j < 4; j++) if (j != m_idx && !ss_n[j]) bad_sel++;
      act = !ss_n[m_idx];
      if (act && !prev_act) begin
        cnt = 0; srx = 0; edges = 0; t_sel = cyc;
        if (m_cpha == 0) miso_r = e_stx[0];
      end else if (act && sclk != prev_sclk) begin
        lead = (sclk != e_cpol[0]);
        edges++;
        if (edges == 1) t_first = cyc;
        t_last = cyc;
        if (m_cpha == 0) begin
          if (lead) begin if (cnt < 16) srx[cnt] = mosi; end
          else begin cnt++; if (cnt < 16) miso_r = e_stx[cnt]; end
        end else begin
          if (lead) begin if (cnt < 16) miso_r = e_stx[cnt]; end
          else begin if (cnt < 16) srx[cnt] = mosi; cnt++; end
        end
      end
      if (!act && prev_act) t_rise = cyc;
      prev_act = act;
      prev_sclk = sclk;
    end
  end

  function automatic int clamp_len(input int l);
    return (l < 3) ? 3 : (l > 16) ? 16 : l;
  endfunction

  // called just after a falling clock edge
  task automatic launch(input logic [15:0] tx, input logic [15:0] stx, input int len,
                        input int pol, input int pha, input int idx, input int dv);
    tx_word = tx; word_len = 5'(len); cpol = pol[0]; cpha = pha[0];
    slave_idx = 2'(idx); divider = 8'(dv);
    e_n = clamp_len(len); e_div = dv; e_cpol = pol; m_cpha = pha; m_idx = idx;
    e_tx = tx; e_stx = stx;
    start = 1;
  endtask

  task automatic finish(input bit disturb, input bit dup);
    int k = 0;
    bit busy_ok = 1;
    logic [15:0] msk;
    msk = 16'hFFFF >> (16 - e_n);
    @(posedge clk);
    forever begin
      @(negedge clk); #1;
      if (k == 0) start = 0;
      if (done) break;
      if (!busy) busy_ok = 0;
      k++;
      if (disturb && k == 3) begin
        tx_word = 16'($urandom); word_len = 5'($urandom_range(3, 16));
        cpol = ~cpol; cpha = ~cpha; slave_idx = slave_idx + 2'd1; divider = divider + 8'd3;
      end
      if (dup && k == 5) begin
        start = 1; tx_word = ~tx_word; slave_idx = slave_idx + 2'd2;
      end
      if (dup && k == 6) start = 0;
      if (k > 20000) break;
    end
    chk(busy_ok, "R8 busy during word", busy_ok, 1);
    chk(k == (2 * e_n + 2) * (e_div + 1), "R7 cycles to done", k, (2 * e_n + 2) * (e_div + 1));
    chk(rx_word == (e_stx & msk), "R4 R3 received word", rx_word, e_stx & msk);
    chk((srx & msk) == (e_tx & msk), "R4 R3 word seen by peripheral", srx & msk, e_tx & msk);
    chk(edges == 2 * e_n, "R1 clock edges", edges, 2 * e_n);
    chk(t_first - t_sel >= e_div + 1, "R6 select setup", t_first - t_sel, e_div + 1);
    chk(t_rise - t_last >= e_div + 1, "R6 select hold", t_rise - t_last, e_div + 1);
    chk(bad_sel == 0, "R5 foreign select", bad_sel, 0);
    chk(!busy && ss_n == 4'hF, "R8 state at done", {busy, ss_n}, 5'h0F);
    chk(sclk == e_cpol[0], "R2 clock rest level", sclk, e_cpol);
    if (dup) begin
      repeat (4) @(negedge clk);
      #1;
      chk(!busy && ss_n == 4'hF, "R9 no extra word", {busy, ss_n}, 5'h0F);
    end
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #1;
    chk(ss_n == 4'hF && !busy && !done, "R8 reset state", {busy, done, ss_n}, 6'h0F);
    chk(sclk == 1'b0, "R2 reset clock level", sclk, 0);
  endtask

  task automatic t_idle_level;
    cpol = 1;
    repeat (2) @(negedge clk);
    #1 chk(sclk == 1'b1, "R2 idle high", sclk, 1);
    cpol = 0;
    repeat (2) @(negedge clk);
    #1 chk(sclk == 1'b0, "R2 idle low", sclk, 0);
  endtask

  task automatic t_word(input logic [15:0] tx, input logic [15:0] stx, input int len,
                        input int pol, input int pha, input int idx, input int dv);
    @(negedge clk); #1;
    launch(tx, stx, len, pol, pha, idx, dv);
    finish(0, 0);
  endtask

  task automatic t_disturb;
    @(negedge clk); #1;
    launch(16'h3C96, 16'hA55A, 11, 0, 1, 2, 2);
    finish(1, 0);
  endtask

  task automatic t_dup_start;
    @(negedge clk); #1;
    launch(16'h00D2, 16'h00B4, 8, 1, 0, 1, 1);
    finish(0, 1);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); #1;
    launch(16'h0071, 16'h0065, 7, 0, 0, 0, 0);
    finish(0, 0);
    // still in the cycle where done is visible: R11
    launch(16'hBEEF, 16'h1357, 16, 1, 1, 3, 1);
    finish(0, 0);
  endtask

  initial begin
    bad_sel = 0; m_idx = 0; e_cpol = 0; m_cpha = 0;
    t_reset();
    t_idle_level();
    t_word(16'h00A7, 16'h005C, 8, 0, 0, 0, 1);   // mode 0
    t_word(16'h00C3, 16'h0019, 8, 0, 1, 1, 2);   // mode 1
    t_word(16'hF00D, 16'h6B2E, 16, 1, 0, 2, 0);  // mode 2, widest
    t_word(16'h0005, 16'h0006, 3, 1, 1, 3, 3);   // mode 3, shortest
    t_word(16'hFFFF, 16'h0002, 1, 0, 0, 1, 0);   // R1 clamp up to 3
    t_word(16'h8421, 16'h7BDE, 31, 1, 0, 0, 1);  // R1 clamp down to 16
    t_disturb();       // R10
    t_dup_start();     // R9
    t_back_to_back();  // R11
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule